// File: doc/BRIEF.md
# Pointer-Indexed Control Register Port

This block sits behind one 8-bit control address of a serial channel. The host reaches sixteen write registers and sixteen read registers through that single address in two steps. First it writes a byte to register 0. That byte names the target register and may also carry an action command and a CRC/latch reset code. The next control access, a read or a write, then goes to the named register. After that one access the pointer falls back to register 0.

Registers 8 to 15 can only be named when the same byte carries the point-high command. The read map and the write map are separate. A read at an index returns a value that the rest of the channel supplies on `rr_in`, not the write register at that index. The one exception is index 15, which reads back the interrupt-enable bits of write register 15. Decoded commands and reset codes leave the block as one-cycle strobes. The contents of all write registers leave it as a flat registered bus.

Top module: `ctl_regfile_port`

## Requirements
- R1: While `rst` is high on a clock edge, the pointer is set to 0, every write register is set to 0x00, and `ctl_rdata`, `cmd_pulse` and `crc_pulse` are set to 0.
- R2: A write accepted while the pointer is 0 whose bits 5:3 are not 3'b001 sets the pointer to bits 2:0 of the byte (registers 0 to 7).
- R3: A write accepted while the pointer is 0 whose bits 5:3 are 3'b001 (point high, 0x08) sets the pointer to 8 plus bits 2:0 of the byte.
- R4: A write accepted while the pointer is 0 with a nonzero command code k in bits 5:3 raises `cmd_pulse[k-1]` for exactly the one cycle after the accepting edge. The codes are: 1 point high, 2 clear status interrupt, 3 send abort, 4 arm interrupt on next receive, 5 clear transmit interrupt pending, 6 clear error, 7 clear highest in-service. Code 0 raises nothing.
- R5: A write accepted while the pointer is 0 with a nonzero reset code j in bits 7:6 raises `crc_pulse[j-1]` for exactly the one cycle after the accepting edge. The codes are: 1 receive CRC checker, 2 transmit CRC generator, 3 transmit underrun/end-of-message latch.
- R6: A pointer, a command code and a reset code carried in one byte all take effect from that single write.
- R7: A read or write to a nonzero pointer returns the pointer to 0 at the same edge.
- R8: A write accepted with the pointer at n stores the byte in write register n only (`wr_regs[8n+7:8n]`; register 0 takes the register-0 byte itself). A write to n greater than 0 raises no strobe, whatever its bit pattern.
- R9: A read accepted with the pointer at n (n from 0 to 14) loads `rr_in[8n+7:8n]` into `ctl_rdata`, visible from the cycle after the edge. Otherwise `ctl_rdata` holds its value.
- R10: A read at pointer 15 returns write register 15 with bits 2 and 0 forced to 0 (mask 0xFA).
- R11: When `ctl_wr` and `ctl_rd` are high together, only the write is carried out: `ctl_rdata` holds, and the pointer follows the write.
- R12: A read at pointer 0 leaves the pointer at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_wr | input | 1 | Control-port write, one access per cycle high |
| ctl_rd | input | 1 | Control-port read, one access per cycle high |
| ctl_wdata | input | 8 | Write byte |
| ctl_rdata | output | 8 | Registered read byte |
| rr_in | input | 120 | Read registers 0 to 14 supplied by the channel, register n at bits 8n+7:8n |
| wr_regs | output | 128 | Write registers 0 to 15, register n at bits 8n+7:8n |
| cmd_pulse | output | 7 | One-cycle command strobes, bit k-1 for command code k |
| crc_pulse | output | 3 | One-cycle reset strobes, bit j-1 for reset code j |

## Verification
A single register-0 byte can load the pointer, raise a command strobe and raise a reset strobe on the same edge. A read and a write can also arrive together on the port. Directed bytes such as 0xED, which names pointer 5 together with command 5 and reset code 3, and random bytes with random write, read and combined operations are checked against a bench model. On every access the model checks that both strobe vectors match the decoded fields, that the pointer lands where the byte says, and that a colliding read leaves the read byte untouched.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;

  // Field positions inside a register-0 byte; the decode depends on them.
  localparam int PTR_LSB = 0;
  localparam int PTR_W   = 3;
  localparam int CMD_LSB = 3;
  localparam int CMD_W   = 3;
  localparam int RSC_LSB = 6;
  localparam int RSC_W   = 2;

  localparam int NUM_CMD = (1 << CMD_W) - 1;
  localparam int NUM_RSC = (1 << RSC_W) - 1;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP      = 3'd0,
    CMD_HIGH     = 3'd1,
    CMD_CLR_EXT  = 3'd2,
    CMD_ABORT    = 3'd3,
    CMD_RX_NEXT  = 3'd4,
    CMD_CLR_TXIP = 3'd5,
    CMD_CLR_ERR  = 3'd6,
    CMD_CLR_IUS  = 3'd7
  } cmd_code_e;

  typedef enum logic [RSC_W-1:0] {
    RSC_NOP    = 2'd0,
    RSC_RX_CRC = 2'd1,
    RSC_TX_CRC = 2'd2,
    RSC_TX_EOM = 2'd3
  } rsc_code_e;

  // Bits of the top write register that survive a read-back.
  localparam logic [7:0] TOP_READ_MASK = 8'hFA;

endpackage

// File: rtl/ctl_cmd_decode.sv
module ctl_cmd_decode
  import ctl_port_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  logic [DW-1:0]      byte_in,
  output logic [NUM_CMD-1:0] cmd_pulse,
  output logic [NUM_RSC-1:0] crc_pulse
);

  logic [CMD_W-1:0] cmd_f;
  logic [RSC_W-1:0] rsc_f;

  assign cmd_f = byte_in[CMD_LSB +: CMD_W];
  assign rsc_f = byte_in[RSC_LSB +: RSC_W];

  for (genvar k = 1; k <= NUM_CMD; k++) begin : g_cmd
    always_ff @(posedge clk) begin
      if (rst) cmd_pulse[k-1] <= 1'b0;
      else     cmd_pulse[k-1] <= fire && (cmd_f == CMD_W'(k));
    end
  end

  for (genvar j = 1; j <= NUM_RSC; j++) begin : g_rsc
    always_ff @(posedge clk) begin
      if (rst) crc_pulse[j-1] <= 1'b0;
      else     crc_pulse[j-1] <= fire && (rsc_f == RSC_W'(j));
    end
  end

endmodule

// File: rtl/ctl_ptr_track.sv
module ctl_ptr_track
  import ctl_port_pkg::*;
#(
  parameter int NREG = 16,
  localparam int AW   = $clog2(NREG),
  localparam int HALF = NREG / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_go,
  input  logic             rd_go,
  input  logic [CMD_W-1:0] cmd_f,
  input  logic [PTR_W-1:0] low_f,
  output logic [AW-1:0]    ptr
);

  logic at_base;
  logic [AW-1:0] base_next;

  assign at_base   = (ptr == '0);
  assign base_next = AW'(low_f) + ((cmd_f == CMD_HIGH) ? AW'(HALF) : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (wr_go) begin
      ptr <= at_base ? base_next : '0;
    end else if (rd_go) begin
      ptr <= '0;
    end
  end

endmodule

// File: rtl/ctl_wreg_bank.sv
module ctl_wreg_bank #(
  parameter int NREG = 16,
  parameter int DW   = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_go,
  input  logic [AW-1:0]      ptr,
  input  logic [DW-1:0]      wdata,
  output logic [NREG*DW-1:0] regs_flat
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                            q <= '0;
      else if (wr_go && ptr == AW'(i))    q <= wdata;
    end
    assign regs_flat[i*DW +: DW] = q;
  end

endmodule

// File: rtl/ctl_regfile_port.sv
module ctl_regfile_port
  import ctl_port_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ctl_wr,
  input  logic                   ctl_rd,
  input  logic [DW-1:0]          ctl_wdata,
  output logic [DW-1:0]          ctl_rdata,
  input  logic [(NREG-1)*DW-1:0] rr_in,
  output logic [NREG*DW-1:0]     wr_regs,
  output logic [NUM_CMD-1:0]     cmd_pulse,
  output logic [NUM_RSC-1:0]     crc_pulse
);

  logic [AW-1:0] ptr;
  logic          rd_go;
  logic          fire;
  logic [DW-1:0] rd_view [NREG];

  // Write wins when both strobes arrive together.
  assign rd_go = ctl_rd && !ctl_wr;
  assign fire  = ctl_wr && (ptr == '0);

  ctl_ptr_track #(.NREG(NREG)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .wr_go (ctl_wr),
    .rd_go (rd_go),
    .cmd_f (ctl_wdata[CMD_LSB +: CMD_W]),
    .low_f (ctl_wdata[PTR_LSB +: PTR_W]),
    .ptr   (ptr)
  );

  ctl_wreg_bank #(.NREG(NREG), .DW(DW)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_go     (ctl_wr),
    .ptr       (ptr),
    .wdata     (ctl_wdata),
    .regs_flat (wr_regs)
  );

  ctl_cmd_decode #(.DW(DW)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .byte_in   (ctl_wdata),
    .cmd_pulse (cmd_pulse),
    .crc_pulse (crc_pulse)
  );

  for (genvar i = 0; i < NREG - 1; i++) begin : g_view
    assign rd_view[i] = rr_in[i*DW +: DW];
  end
  assign rd_view[NREG-1] = wr_regs[(NREG-1)*DW +: DW] & DW'(TOP_READ_MASK);

  always_ff @(posedge clk) begin
    if (rst)        ctl_rdata <= '0;
    else if (rd_go) ctl_rdata <= rd_view[ptr];
  end

endmodule

// File: rtl/ctl_regfile_port_chk.sv
module ctl_regfile_port_chk #(
  parameter int NREG = 16,
  parameter int DW   = 8,
  localparam int AW  = $clog2(NREG)
) (
  input logic               clk,
  input logic               rst,
  input logic               ctl_wr,
  input logic               ctl_rd,
  input logic [DW-1:0]      ctl_wdata,
  input logic [AW-1:0]      ptr,
  input logic [DW-1:0]      ctl_rdata,
  input logic [NREG*DW-1:0] wr_regs,
  input logic [6:0]         cmd_pulse,
  input logic [2:0]         crc_pulse
);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wr_regs == '0 && ptr == '0 && ctl_rdata == '0)); // R1

  AST_PTR_LOW_BANK: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ptr == '0 && ctl_wdata[5:3] != 3'd1) |=> (ptr < AW'(NREG/2))); // R2

  AST_PTR_HIGH_BANK: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ptr == '0 && ctl_wdata[5:3] == 3'd1) |=> (ptr >= AW'(NREG/2))); // R3

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_pulse) && $onehot0(crc_pulse)); // R4

  AST_STROBE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (|cmd_pulse || |crc_pulse) |-> $past(ctl_wr && ptr == '0)); // R8

  AST_PTR_RETURN: assert property (@(posedge clk) disable iff (rst)
    ((ctl_wr || ctl_rd) && ptr != '0) |=> (ptr == '0)); // R7

  AST_TOP_MASK: assert property (@(posedge clk) disable iff (rst)
    $past(ctl_rd && !ctl_wr && ptr == AW'(NREG-1)) |-> (ctl_rdata[2] == 1'b0 && ctl_rdata[0] == 1'b0)); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> $stable(ctl_rdata)); // R11

endmodule

bind ctl_regfile_port ctl_regfile_port_chk #(.NREG(NREG), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctl_wr    (ctl_wr),
  .ctl_rd    (ctl_rd),
  .ctl_wdata (ctl_wdata),
  .ptr       (ptr),
  .ctl_rdata (ctl_rdata),
  .wr_regs   (wr_regs),
  .cmd_pulse (cmd_pulse),
  .crc_pulse (crc_pulse)
);

// File: tb/ctl_regfile_port_tb.sv
module ctl_regfile_port_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ctl_wr = 1'b0;
  logic         ctl_rd = 1'b0;
  logic [7:0]   ctl_wdata = '0;
  logic [7:0]   ctl_rdata;
  logic [119:0] rr_in;
  logic [127:0] wr_regs;
  logic [6:0]   cmd_pulse;
  logic [2:0]   crc_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] mwr [16];
  logic [7:0] rrm [15];
  logic [3:0] mptr;
  logic [7:0] mrd;

  always #2 clk = ~clk;

  ctl_regfile_port u_dut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .rr_in(rr_in),
    .wr_regs(wr_regs), .cmd_pulse(cmd_pulse), .crc_pulse(crc_pulse)
  );

  function automatic logic [6:0] exp_cmd(input logic [7:0] b);
    return (b[5:3] == 3'd0) ? 7'd0 : 7'(1 << (b[5:3] - 3'd1));
  endfunction

  function automatic logic [2:0] exp_crc(input logic [7:0] b);
    return (b[7:6] == 2'd0) ? 3'd0 : 3'(1 << (b[7:6] - 2'd1));
  endfunction

  function automatic logic [3:0] exp_ptr(input logic [7:0] b);
    return (b[5:3] == 3'd1) ? {1'b1, b[2:0]} : {1'b0, b[2:0]};
  endfunction

  function automatic logic [127:0] pack_wr();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = mwr[i];
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) mwr[i] = 8'h00;
    mptr = 4'd0;
    mrd  = 8'h00;
  endtask

  // Called at a falling edge; drives one access and checks its results.
  task automatic access(input bit w, input bit r, input logic [7:0] b);
    logic [6:0] ec;
    logic [2:0] er;
    string rtag;
    ec = '0; er = '0; rtag = "R9 hold";
    ctl_wr = w; ctl_rd = r; ctl_wdata = b;
    if (w) begin
      if (mptr == 4'd0) begin
        mwr[0] = b; ec = exp_cmd(b); er = exp_crc(b); mptr = exp_ptr(b);
      end else begin
        mwr[mptr] = b; mptr = 4'd0;
      end
      if (r) rtag = "R11";
    end else if (r) begin
      if (mptr == 4'd15) begin mrd = mwr[15] & 8'hFA; rtag = "R10"; end
      else begin mrd = rrm[mptr]; rtag = (mptr == 4'd0) ? "R12" : "R9"; end
      mptr = 4'd0;
    end
    @(posedge clk); @(negedge clk);
    chk(cmd_pulse === ec, "R4 R6 cmd strobe", 128'(cmd_pulse), 128'(ec));
    chk(crc_pulse === er, "R5 R6 reset strobe", 128'(crc_pulse), 128'(er));
    chk(wr_regs === pack_wr(), "R2 R3 R7 R8 write map", wr_regs, pack_wr());
    chk(ctl_rdata === mrd, rtag, 128'(ctl_rdata), 128'(mrd));
    ctl_wr = 1'b0; ctl_rd = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(cmd_pulse === 7'd0 && crc_pulse === 3'd0, "R4 R5 one-cycle strobe",
        128'({cmd_pulse, crc_pulse}), 128'(0));
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 15; i++) begin
      rrm[i] = {4'(i), 4'($urandom)};
      rr_in[i*8 +: 8] = rrm[i];
    end
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(wr_regs === '0 && cmd_pulse === '0 && crc_pulse === '0 && ctl_rdata === '0,
        "R1 reset state", wr_regs, 128'(0));

    access(0, 1, 8'h00);                 // R12 read at base
    access(0, 1, 8'h00);                 // R12 still at base
    access(1, 0, 8'h03);                 // R2 point to 3
    access(1, 0, 8'h38);                 // R8 command-like data, no strobe
    access(0, 1, 8'h00);                 // R7 back at 0
    access(1, 0, 8'h0F);                 // R3 point to 15
    access(1, 0, 8'hFF);
    access(1, 0, 8'h0F);
    access(0, 1, 8'h00);                 // R10 reads 0xFA
    access(1, 0, 8'hED);                 // R6 ptr 5, cmd 5, reset 3
    access(1, 0, 8'h5A);
    access(1, 0, 8'h0A);                 // R3 point to 10
    access(1, 1, 8'h77);                 // R11 write only
    access(1, 0, 8'h08);                 // R3 point to 8
    access(0, 1, 8'h00);                 // R9 read of rr_in 8
    access(1, 0, 8'h06);
    access(0, 1, 8'h00);                 // R9 read of rr_in 6
    for (int k = 0; k < 8; k++) begin    // R4 R5 every code
      access(1, 0, {2'(k % 4), 3'(k), 3'b000});
      if (k == 1) access(0, 1, 8'h00);
    end

    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom % 4);
      access(op != 2, op >= 2, 8'($urandom));
      if (n == 200) begin
        rst = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst = 1'b0;
        model_reset();
        chk(wr_regs === '0 && ctl_rdata === '0, "R1 mid-run reset", wr_regs, 128'(0));
        access(0, 1, 8'h00);             // R1 pointer back at 0
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule